// File: doc/BRIEF.md
# Reset Source Controller with Flash Guard

This block merges the reset causes of a small microcontroller into one synchronous system reset and keeps a status byte that records which cause fired last. Every flash access the CPU makes is screened on its way to the flash. This covers instruction fetches, data reads from code space, writes and page erases. Each access is compared with a lock-byte address that is supplied at run time, and with a per-access security-restriction input. An access that breaks a rule becomes a flash-error reset.

Three further sources are combined with the flash guard. The first is an external reset request that has already been synchronized. The second is a pair of real-time-clock events: an alarm match, and a missing-clock result that comes from another clock domain. The third is a software request made through a one-byte register write. The RTC sources cause a reset only while the RTC-reset enable bit is set. None of the internally sourced resets drives the external reset pin, and this block has no pin output at all. Each reset is stretched to a fixed number of clocks. The cause flags are rewritten when the reset is released.

Top module: `rst_cause_ctl`

## Requirements
- R1: A write (acc_kind=2) or erase (acc_kind=3) with flash_wr_en=1 whose acc_addr is strictly greater than lock_addr raises a flash-error reset. A target equal to lock_addr does not raise one.
- R2: An instruction fetch (acc_kind=0) or a data read (acc_kind=1) whose address is above lock_addr raises a flash-error reset.
- R3: A data read, or a write or erase with flash_wr_en=1, that is made while acc_secure_blk=1 raises a flash-error reset at any address.
- R4: A write or erase with flash_wr_en=1 that is made while vmon_en=0 raises a flash-error reset.
- R5: A write or erase with flash_wr_en=0 is not a flash access. It causes no reset, whatever its address, security or monitor state.
- R6: When status bit 7 (RTC-reset enable, read/write) is 1, an alarm event (rtc_alarm_en & rtc_alarm_hit) raises a reset that is recorded in status bit 5. When bit 7 is 0, the alarm causes no reset.
- R7: rtc_clk_slow passes through two synchronizer flops. With rtc_mcd_en=1, a rise on it starts the reset after the third rising clock edge.
- R8: A register write with reg_wdata bit 4 = 1 forces a software reset, and status bit 4 reads 1 after that reset. A register write also loads reg_wdata bit 7 into status bit 7.
- R9: sys_rst rises on the clock edge after the one that samples a request. It stays high for exactly STRETCH cycles (default 4). Requests and register writes that arrive while it is high are ignored.
- R10: When sys_rst falls, exactly one cause flag is set: 6 flash, 5 RTC, 4 software, 0 pin. Bits 3, 2 and 1 read 0, and bit 7 keeps its value.
- R11: After por_n is released, status reads 8'h02 (bit 1 = power-on) and sys_rst is 0.
- R12: When requests arrive in the same cycle, the cause recorded follows this priority: pin first, then flash, then RTC, then software.
- R13: ext_rst_req causes a reset that is recorded in status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_req | input | 1 | Synchronized external reset request |
| acc_valid | input | 1 | Flash access strobe |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2 write, 3 erase |
| acc_addr | input | ADDR_W | Access target address |
| lock_addr | input | ADDR_W | Lock-byte address, highest legal address |
| acc_secure_blk | input | 1 | Security settings forbid this access |
| flash_wr_en | input | 1 | Flash write/erase enable control |
| vmon_en | input | 1 | Supply-voltage monitor enabled |
| rtc_alarm_en | input | 1 | RTC alarm enabled |
| rtc_alarm_hit | input | 1 | RTC timer equals alarm value |
| rtc_mcd_en | input | 1 | RTC missing-clock detector enabled |
| rtc_clk_slow | input | 1 | RTC clock below threshold, asynchronous |
| reg_we | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| sys_rst | output | 1 | Stretched synchronous system reset |
| status | output | 8 | Reset status register |

## Verification
The bench builds the block with ADDR_W=12 and STRETCH=5. The narrow address makes the whole space reachable, so the bench can set the lock at 12'h7FF and probe exactly at the lock, just above it, and at the top address 12'hFFF. A stretch of 5 instead of the default 4 shows that the pulse length tracks the parameter. It also leaves room to fire a second request in the middle of a reset and confirm that it is dropped.

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl #(
  parameter int ADDR_W  = 16,
  parameter int STRETCH = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_req,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              acc_secure_blk,
  input  logic              flash_wr_en,
  input  logic              vmon_en,
  input  logic              rtc_alarm_en,
  input  logic              rtc_alarm_hit,
  input  logic              rtc_mcd_en,
  input  logic              rtc_clk_slow,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic              sys_rst,
  output logic [7:0]        status
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [1:0] K_DREAD = 2'd1;

  logic [CW-1:0] cnt;
  logic [1:0]    slow_q;
  logic [3:0]    cause_q, req_vec, pick;
  logic          above, is_mod, flash_err, rtc_req, sw_req, unused_wbits;

  assign above     = acc_addr > lock_addr;
  assign is_mod    = acc_kind[1];
  assign flash_err = acc_valid & (is_mod ? flash_wr_en & (above | acc_secure_blk | ~vmon_en)
                                         : above | (acc_kind == K_DREAD && acc_secure_blk));
  assign rtc_req   = status[7] & ((rtc_alarm_en & rtc_alarm_hit) | (rtc_mcd_en & slow_q[1]));
  assign sw_req    = reg_we & reg_wdata[4];
  assign req_vec   = {ext_rst_req, flash_err, rtc_req, sw_req};
  assign pick      = req_vec[3] ? 4'b1000 : req_vec[2] ? 4'b0100 :
                     req_vec[1] ? 4'b0010 : req_vec[0] ? 4'b0001 : 4'b0000;
  assign sys_rst   = cnt != '0;
  assign unused_wbits = ^{reg_wdata[6:5], reg_wdata[3:0]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      slow_q  <= '0;
      cnt     <= '0;
      cause_q <= '0;
      status  <= 8'h02;
    end else begin
      slow_q <= {slow_q[0], rtc_clk_slow};
      if (cnt == '0) begin
        if (|req_vec) begin
          cnt     <= CW'(STRETCH);
          cause_q <= pick;
        end
        if (reg_we) status[7] <= reg_wdata[7];
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1))
          status[6:0] <= {cause_q[2], cause_q[1], cause_q[0], 3'b000, cause_q[3]};
      end
    end
  end

  p_flash_starts_r1: assert property (@(posedge clk) disable iff (!por_n)
    (flash_err && !sys_rst) |=> sys_rst);

  p_sw_starts_r8: assert property (@(posedge clk) disable iff (!por_n)
    (sw_req && !sys_rst) |=> sys_rst);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !ext_rst_req && !flash_err && !rtc_req && !sw_req) |=> !sys_rst);

  p_one_cause_r10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> ($countones({status[6:4], status[0]}) == 1 && status[3:1] == 3'b000));

  p_enable_kept_r10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> $stable(status[7]));

  p_rtc_gated_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!status[7] && !sys_rst && !ext_rst_req && !flash_err && !sw_req) |=> !sys_rst);
endmodule

// File: tb/sim_rst_cause_ctl.sv
module sim_rst_cause_ctl;
  localparam int AW = 12;
  localparam int ST = 5;

  logic clk = 0, por_n = 0;
  logic ext_rst_req = 0, acc_valid = 0, acc_secure_blk = 0, flash_wr_en = 0, vmon_en = 1;
  logic [1:0] acc_kind = 0;
  logic [AW-1:0] acc_addr = 0, lock_addr = 12'h7FF;
  logic rtc_alarm_en = 0, rtc_alarm_hit = 0, rtc_mcd_en = 0, rtc_clk_slow = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic sys_rst;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0, hi_cnt = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rst_cause_ctl #(.ADDR_W(AW), .STRETCH(ST)) u0 (
    .clk, .por_n, .ext_rst_req, .acc_valid, .acc_kind, .acc_addr, .lock_addr,
    .acc_secure_blk, .flash_wr_en, .vmon_en, .rtc_alarm_en, .rtc_alarm_hit,
    .rtc_mcd_en, .rtc_clk_slow, .reg_we, .reg_wdata, .sys_rst, .status);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && sys_rst) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected reset", hi_cnt, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(hi_cnt == ST, {t, " R9 pulse length"}, hi_cnt, ST);
        chk(status == e, {t, " R10 status"}, status, e);
      end
      hi_cnt = 0;
    end
  end

  task automatic acc(input logic [1:0] k, input logic [AW-1:0] a,
                     input logic wren, input logic vm, input logic sec);
    @(negedge clk);
    acc_kind = k; acc_addr = a; flash_wr_en = wren; vmon_en = vm; acc_secure_blk = sec;
    acc_valid = 1;
    @(negedge clk);
    acc_valid = 0; flash_wr_en = 0; vmon_en = 1; acc_secure_blk = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic expect_rst(input logic [7:0] e, input string t);
    chk(sys_rst == 1, {t, " reset started"}, sys_rst, 1);
    exp_q.push_back(e);
    tag_q.push_back(t);
    repeat (ST + 1) @(negedge clk);
  endtask

  task automatic expect_quiet(input logic [7:0] e, input string t);
    chk(sys_rst == 0, {t, " no reset"}, sys_rst, 0);
    @(negedge clk);
    chk(sys_rst == 0 && status == e, {t, " status kept"}, status, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk(status == 8'h02, "R11 status", status, 8'h02);
    chk(sys_rst == 0, "R11 sys_rst", sys_rst, 0);

    acc(2'd2, 12'h800, 1, 1, 0); expect_rst(8'h40, "R1 write above lock");
    wr(8'h10);                   expect_rst(8'h10, "R8 software");
    acc(2'd3, 12'h7FF, 1, 1, 0); expect_quiet(8'h10, "R1 erase at lock");
    acc(2'd3, 12'hFFF, 0, 0, 1); expect_quiet(8'h10, "R5 no write enable");
    acc(2'd0, 12'h900, 0, 1, 0); expect_rst(8'h40, "R2 fetch above lock");
    wr(8'h10);                   expect_rst(8'h10, "R8 software again");
    acc(2'd1, 12'hFFF, 0, 1, 0); expect_rst(8'h40, "R2 data read at top");
    wr(8'h10);                   expect_rst(8'h10, "R8 software");
    acc(2'd1, 12'h100, 0, 1, 1); expect_rst(8'h40, "R3 secured read");
    wr(8'h10);                   expect_rst(8'h10, "R8 software");
    acc(2'd3, 12'h010, 1, 1, 1); expect_rst(8'h40, "R3 secured erase");
    wr(8'h10);                   expect_rst(8'h10, "R8 software");
    acc(2'd3, 12'h200, 1, 0, 0); expect_rst(8'h40, "R4 erase monitor off");

    @(negedge clk); rtc_alarm_en = 1; rtc_alarm_hit = 1;
    @(negedge clk); expect_quiet(8'h40, "R6 alarm while disabled");
    rtc_alarm_hit = 0;
    wr(8'h80); expect_quiet(8'hC0, "R8 enable bit write");
    @(negedge clk); rtc_alarm_hit = 1;
    @(negedge clk); rtc_alarm_hit = 0; rtc_alarm_en = 0;
    expect_rst(8'hA0, "R6 alarm reset");

    @(negedge clk); ext_rst_req = 1;
    @(negedge clk); ext_rst_req = 0; expect_rst(8'h81, "R13 pin reset");

    @(negedge clk); rtc_mcd_en = 1; rtc_clk_slow = 1;
    @(negedge clk); chk(sys_rst == 0, "R7 sync stage 1", sys_rst, 0);
    @(negedge clk); chk(sys_rst == 0, "R7 sync stage 2", sys_rst, 0);
    @(negedge clk); rtc_clk_slow = 0; rtc_mcd_en = 0;
    expect_rst(8'hA0, "R7 oscillator fail");

    @(negedge clk);
    ext_rst_req = 1; reg_we = 1; reg_wdata = 8'h90;
    acc_kind = 2'd0; acc_addr = 12'hA00; acc_valid = 1;
    @(negedge clk);
    ext_rst_req = 0; reg_we = 0; acc_valid = 0;
    expect_rst(8'h81, "R12 pin wins");

    @(negedge clk);
    reg_we = 1; reg_wdata = 8'h90; acc_kind = 2'd1; acc_addr = 12'hC00; acc_valid = 1;
    @(negedge clk);
    reg_we = 0; acc_valid = 0;
    expect_rst(8'hC0, "R12 flash over software");

    wr(8'h90);
    chk(sys_rst == 1, "R9 reset running", sys_rst, 1);
    exp_q.push_back(8'h90); tag_q.push_back("R9 request during reset");
    acc(2'd0, 12'hFFF, 0, 1, 0);
    wr(8'h00);
    repeat (ST + 3) @(negedge clk);
    chk(status == 8'h90, "R9 late requests ignored", status, 8'h90);
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule